// File: doc/BRIEF.md
# Misaligned Word Load Unit

This block sits between a processor load stage and a 32-bit data memory that is addressed by word. It accepts a word load at any byte address and returns a 32-bit result. When the two low address bits are zero the load is a plain single-word read. When they are not, a per-request mode input picks one of three policies:

- **In-word rotate.** Rotate the containing word.
- **Fault.** Refuse the access and flag an alignment fault.
- **Split.** Perform a true unaligned access. Fetch the containing word and the word after it, then assemble the four addressed bytes in little-endian order.

A small sequencer issues the memory reads. The memory port has one cycle of read latency. While a request is in flight the request port reports not-ready. Each result is presented with a single-cycle valid strobe and a fault flag.

Top module: `ualign_load_unit`

## Requirements
- R1: After a synchronous active-high reset, `resp_valid`, `resp_fault` and `mem_rd_en` are low and `req_ready` is high.
- R2: A load whose address has bits 1:0 equal to zero returns the word at word address `req_addr[31:2]` unchanged, with `resp_fault` low, in every mode. It issues exactly one memory read, and the response appears two clock edges after the accepting edge.
- R3: With `req_mode` = 0 (rotate), a misaligned load performs one read of the containing word. It returns that word rotated right by 8 × `req_addr[1:0]`, so the addressed byte lands in bits 7:0. The response appears two edges after acceptance.
- R4: With `req_mode` = 1 (fault), a misaligned load issues no memory read. It returns `resp_fault` high with `resp_data` zero, one edge after acceptance.
- R5: With `req_mode` = 2 (split), a misaligned load returns the bytes at addresses A, A+1, A+2 and A+3, with byte A in bits 7:0.
  - It issues two reads: first the containing word, then the next word.
  - It never uses bytes below A.
  - The response appears three edges after acceptance.
- R6: In split mode the second read's word address is the first plus one modulo 2^30. A request in the last word of the address space therefore reads word 0 second.
- R7: `resp_valid` stays high for exactly one cycle per request, and `resp_fault` is never high while `resp_valid` is low.
- R8: `req_ready` is low from the accepting edge until the response cycle, and `mem_rd_en` is never high while `req_ready` is high.
- R9: The unused mode encoding 3 behaves as fault mode for misaligned addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the word load |
| req_mode | input | 2 | Misalignment policy: 0 rotate, 1 fault, 2 split, 3 fault |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W-2 | Word address of the read |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after the strobe |
| resp_valid | output | 1 | Result strobe, one cycle |
| resp_data | output | DATA_W | Loaded word, zero on fault |
| resp_fault | output | 1 | Alignment fault, meaningful with resp_valid |

## Verification
The bench walks all four byte offsets in each mode against a byte-array model. A design that rotated in the wrong direction, or merged with the preceding word instead of the following one, would return a byte-permuted word. That is the exact symptom a broken unaligned path shows. The split case at the top of the address space catches a second read that fails to wrap, or that reuses the first word. Read counts and response latencies are compared per case. A design that read memory on a fault, skipped the second fetch, or stretched the valid strobe would show the wrong count or timing. Mode 3 and aligned loads in fault mode are checked so that a fault is raised only for a misaligned address.

// File: rtl/ualign_pkg.sv
package ualign_pkg;

  typedef enum logic [1:0] {
    LD_ROTATE = 2'd0,
    LD_FAULT  = 2'd1,
    LD_SPLIT  = 2'd2,
    LD_RSVD   = 2'd3
  } ld_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ0 = 2'd1,
    ST_READ1 = 2'd2,
    ST_RESP  = 2'd3
  } ld_state_e;

  function automatic logic mode_faults(input ld_mode_e m);
    return (m == LD_FAULT) || (m == LD_RSVD);
  endfunction

endpackage

// File: rtl/ualign_seq.sv
module ualign_seq
  import ualign_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_mode,
  output logic               req_ready,
  output logic               mem_rd_en,
  output logic [WADDR_W-1:0] mem_rd_addr,
  output logic [OFF_W-1:0]   cap_off,
  output logic               cap_split,
  output logic               cap_fault,
  output logic               take_lo,
  output logic               fire
);

  ld_state_e state_q;
  ld_mode_e  mode_in;
  logic      mis_in;

  assign mode_in   = ld_mode_e'(req_mode);
  assign mis_in    = (req_addr[OFF_W-1:0] != '0);
  assign req_ready = (state_q == ST_IDLE);
  assign take_lo   = (state_q == ST_READ1);
  assign fire      = (state_q == ST_RESP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      cap_off     <= '0;
      cap_split   <= 1'b0;
      cap_fault   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            cap_off   <= req_addr[OFF_W-1:0];
            cap_split <= mis_in && (mode_in == LD_SPLIT);
            cap_fault <= mis_in && mode_faults(mode_in);
            if (mis_in && mode_faults(mode_in)) begin
              mem_rd_en <= 1'b0;
              state_q   <= ST_RESP;
            end else begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= req_addr[ADDR_W-1:OFF_W];
              state_q     <= ST_READ0;
            end
          end
        end
        ST_READ0: begin
          if (cap_split) begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= mem_rd_addr + 1'b1;
            state_q     <= ST_READ1;
          end else begin
            mem_rd_en <= 1'b0;
            state_q   <= ST_RESP;
          end
        end
        ST_READ1: begin
          mem_rd_en <= 1'b0;
          state_q   <= ST_RESP;
        end
        default: begin
          mem_rd_en <= 1'b0;
          state_q   <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/ualign_rot.sv
module ualign_rot #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] word_out
);

  always_comb begin
    for (int i = 0; i < BYTES; i++) begin
      logic [OFF_W-1:0] src;
      src = off + OFF_W'(i);
      word_out[i*8 +: 8] = word_in[src*8 +: 8];
    end
  end

endmodule

// File: rtl/ualign_join.sv
module ualign_join #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] word_out
);

  logic [2*DATA_W-1:0] pair;
  assign pair = {hi_word, lo_word};

  always_comb begin
    for (int i = 0; i < BYTES; i++) begin
      logic [OFF_W:0] src;
      src = {1'b0, off} + (OFF_W+1)'(i);
      word_out[i*8 +: 8] = pair[src*8 +: 8];
    end
  end

endmodule

// File: rtl/ualign_load_unit.sv
module ualign_load_unit
  import ualign_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES   = DATA_W / 8,
  localparam int OFF_W   = $clog2(BYTES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_mode,
  output logic               mem_rd_en,
  output logic [WADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0]  mem_rd_data,
  output logic               resp_valid,
  output logic [DATA_W-1:0]  resp_data,
  output logic               resp_fault
);

  logic [OFF_W-1:0]  cap_off;
  logic              cap_split, cap_fault, take_lo, fire;
  logic [DATA_W-1:0] lo_q, rot_w, join_w;

  ualign_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_mode(req_mode),
    .req_ready(req_ready),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .cap_off(cap_off), .cap_split(cap_split), .cap_fault(cap_fault),
    .take_lo(take_lo), .fire(fire)
  );

  ualign_rot #(.DATA_W(DATA_W)) u_rot (
    .word_in(mem_rd_data), .off(cap_off), .word_out(rot_w)
  );

  ualign_join #(.DATA_W(DATA_W)) u_join (
    .lo_word(lo_q), .hi_word(mem_rd_data), .off(cap_off), .word_out(join_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
    end else if (take_lo) begin
      lo_q <= mem_rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_data  <= '0;
    end else if (fire) begin
      resp_valid <= 1'b1;
      resp_fault <= cap_fault;
      if (cap_fault)      resp_data <= '0;
      else if (cap_split) resp_data <= join_w;
      else                resp_data <= rot_w;
    end else begin
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
    end
  end

endmodule

// File: rtl/ualign_load_unit_chk.sv
module ualign_load_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int OFF_W   = $clog2(DATA_W / 8),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [1:0]         req_mode,
  input logic               mem_rd_en,
  input logic [WADDR_W-1:0] mem_rd_addr,
  input logic               resp_valid,
  input logic [DATA_W-1:0]  resp_data,
  input logic               resp_fault
);

  // R7
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R7
  fault_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    resp_fault |-> resp_valid);

  // R4
  fault_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    resp_fault |-> (resp_data == '0));

  // R8
  read_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);

  // R6
  next_word_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |->
      (mem_rd_addr == WADDR_W'($past(mem_rd_addr) + 1'b1)));

  // R4
  fault_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_mode[0] && (req_addr[OFF_W-1:0] != '0))
      |=> !mem_rd_en);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind ualign_load_unit ualign_load_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_mode(req_mode), .mem_rd_en(mem_rd_en),
  .mem_rd_addr(mem_rd_addr), .resp_valid(resp_valid), .resp_data(resp_data),
  .resp_fault(resp_fault)
);

// File: tb/ualign_load_unit_test.sv
module ualign_load_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_mode = '0;
  logic        mem_rd_en;
  logic [29:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic        resp_valid;
  logic [31:0] resp_data;
  logic        resp_fault;

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  logic [29:0] last_rd = '0;
  logic [7:0] bmem [64];

  always #5 clk = ~clk;

  ualign_load_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mode(req_mode), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_fault(resp_fault)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= {bmem[{mem_rd_addr[3:0], 2'd3}], bmem[{mem_rd_addr[3:0], 2'd2}],
                      bmem[{mem_rd_addr[3:0], 2'd1}], bmem[{mem_rd_addr[3:0], 2'd0}]};
      rd_cnt  <= rd_cnt + 1;
      last_rd <= mem_rd_addr;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input logic [31:0] a);
    return bmem[a[5:0]];
  endfunction

  function automatic logic [31:0] expect_word(input logic [31:0] a, input logic [1:0] m);
    logic [31:0] r;
    logic [31:0] base;
    base = {a[31:2], 2'b00};
    for (int i = 0; i < 4; i++) begin
      if (a[1:0] == 2'd0)  r[i*8 +: 8] = mb(base + i);
      else if (m == 2'd0)  r[i*8 +: 8] = mb(base + ((a[1:0] + i) % 4));
      else if (m == 2'd2)  r[i*8 +: 8] = mb(a + i);
      else                 r[i*8 +: 8] = 8'h00;
    end
    return r;
  endfunction

  task automatic do_load(input logic [31:0] a, input logic [1:0] m,
                         output logic [31:0] d, output logic f, output int lat,
                         output int nrd, output logic busy, output logic pulse);
    int r0;
    @(negedge clk);
    req_addr  = a;
    req_mode  = m;
    req_valid = 1'b1;
    r0 = rd_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    busy = !req_ready;
    lat = 0;
    while (!resp_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    d = resp_data;
    f = resp_fault;
    @(negedge clk);
    pulse = !resp_valid && !resp_fault;
    nrd = rd_cnt - r0;
  endtask

  task automatic run_case(input logic [31:0] a, input logic [1:0] m, input string tag);
    logic [31:0] d, e;
    logic f, busy, pulse, efault;
    int lat, nrd, elat, enrd;
    do_load(a, m, d, f, lat, nrd, busy, pulse);
    e = expect_word(a, m);
    efault = (a[1:0] != 2'd0) && m[0];
    if (a[1:0] == 2'd0)  begin elat = 2; enrd = 1; end
    else if (efault)     begin elat = 1; enrd = 0; end
    else if (m == 2'd2)  begin elat = 3; enrd = 2; end
    else                 begin elat = 2; enrd = 1; end
    check(d == e, {tag, " data"}, d, e);
    check(f == efault, {tag, " fault"}, 32'(f), 32'(efault));
    check(lat == elat, {tag, " latency"}, 32'(lat), 32'(elat));
    check(nrd == enrd, {tag, " reads"}, 32'(nrd), 32'(enrd));
    check(busy, "R8 ready low after accept", 32'(!busy), 32'(0));
    check(pulse, "R7 single cycle response", 32'(!pulse), 32'(0));
  endtask

  task automatic t_reset;
    check(!resp_valid && !resp_fault, "R1 resp idle", {30'd0, resp_valid, resp_fault}, 32'd0);
    check(!mem_rd_en, "R1 no read", 32'(mem_rd_en), 32'd0);
    check(req_ready, "R1 ready high", 32'(req_ready), 32'd1);
  endtask

  task automatic t_aligned;
    for (int m = 0; m < 4; m++) run_case(32'h0000_0010, 2'(m), "R2 aligned");
  endtask

  task automatic t_rotate;
    for (int o = 1; o < 4; o++) run_case(32'h0000_0020 + o, 2'd0, "R3 rotate");
  endtask

  task automatic t_fault;
    for (int o = 1; o < 4; o++) run_case(32'h0000_0024 + o, 2'd1, "R4 fault");
    for (int o = 1; o < 4; o++) run_case(32'h0000_0028 + o, 2'd3, "R9 reserved mode");
  endtask

  task automatic t_split;
    for (int o = 1; o < 4; o++) run_case(32'h0000_0030 + o, 2'd2, "R5 split");
  endtask

  task automatic t_example;
    logic [31:0] d;
    logic f, busy, pulse;
    int lat, nrd;
    do_load(32'h4030_23cd, 2'd0, d, f, lat, nrd, busy, pulse);
    check(d == 32'h4E4B_4C4D, "R3 example rotate", d, 32'h4E4B_4C4D);
    do_load(32'h4030_23cd, 2'd2, d, f, lat, nrd, busy, pulse);
    check(d == 32'h484B_4C4D, "R5 example split", d, 32'h484B_4C4D);
  endtask

  task automatic t_wrap;
    logic [31:0] d, e;
    logic f, busy, pulse;
    int lat, nrd;
    e = expect_word(32'hFFFF_FFFE, 2'd2);
    do_load(32'hFFFF_FFFE, 2'd2, d, f, lat, nrd, busy, pulse);
    check(d == e, "R6 wrap data", d, e);
    check(last_rd == 30'd0, "R6 wrap second address", {2'b0, last_rd}, 32'd0);
    check(nrd == 2, "R6 wrap reads", 32'(nrd), 32'd2);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) bmem[i] = 8'(8'h90 + i * 7);
    bmem[12] = 8'h4E; bmem[13] = 8'h4D; bmem[14] = 8'h4C; bmem[15] = 8'h4B; bmem[16] = 8'h48;
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_aligned;
    t_rotate;
    t_fault;
    t_split;
    t_example;
    t_wrap;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule